// File: doc/BRIEF.md
# Aligned Dual-Ratio Clock Divider

This block derives two related slower clocks from one input clock. One output always runs at half the input rate. The other runs at a quarter or a sixth of the input rate, as a select input chooses. Both outputs come from a single shared phase counter, so wherever their rising edges meet they switch on the same input edge. A one-cycle marker pulse flags each of those shared rising points. Downstream logic can use the marker to line its own sequencing up with the divided clocks.

An enable input gates the divider. The enable is captured on the falling edge of the input clock, so gating starts or stops only while the internal clock is low, and no shortened pulse reaches the counter. A synchronous master reset clears every divider flop. Several instances reset together then start in lockstep. Each divided clock is driven on two identically registered copies.

Top module: `mrd_clk_divider`

## Requirements
- R1: While enabled, each half-rate output toggles on every rising input edge, giving a 50% duty cycle.
- R2: With `ratio_sel` = 0, each slow output has a period of 4 enabled cycles: high for 2, then low for 2.
- R3: With `ratio_sel` = 1, each slow output has a period of 6 enabled cycles: high for 3, then low for 3.
- R4: Every rising edge of the slow output occurs on the same input edge as a rising edge of the half-rate output.
- R5: `en` is captured on the falling input edge, so a change made after a rising edge first takes effect at the next rising edge.
- R6: While the captured enable is low, all divided outputs hold their values. No partial or shortened cycle is produced.
- R7: `phase_o` is high for exactly one input cycle, in the cycle in which both divided outputs have just risen together. It is low at all other times.
- R8: While `mrst` is high, all outputs are low. After release, the first enabled rising edge raises every divided output and `phase_o` together.
- R9: A change of `ratio_sel` takes effect only at a shared rising point. A slow-output period already in progress completes at its old length.
- R10: The two copies of each divided clock are equal on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock. Counter and outputs update on its rising edge; enable is captured on its falling edge |
| mrst | input | 1 | Synchronous master reset, active high |
| en | input | 1 | Divider enable, captured on the falling edge |
| ratio_sel | input | 1 | Slow-output ratio: 0 divides by 4, 1 divides by 6 |
| div2_o | output | NCOPY (2) | Copies of the half-rate clock |
| divn_o | output | NCOPY (2) | Copies of the quarter- or sixth-rate clock |
| phase_o | output | 1 | One-cycle marker at each shared rising point |

## Verification
Some properties are checked on every cycle. The half-rate output toggles on each enabled edge, and the outputs hold while disabled. The slow output never rises alone. The marker lasts one cycle and only appears while both clocks are high. The active ratio changes only at a counter wrap. Other behaviours need the bench's reference model over whole scenarios. These are the exact 2/2 and 3/3 duty patterns, the falling-edge timing of the enable, and the outputs after reset release. The model also shows that a select change made mid-period leaves the running period at its old length.

// File: rtl/mrd_pkg.sv
package mrd_pkg;

  // Phase position that follows `ph` in a cycle of `per` steps.
  function automatic int ph_after(input int ph, input int per);
    if (ph >= per - 1) return 0;
    return ph + 1;
  endfunction

  // Slow clock is high for positions 1 .. per/2 of its cycle.
  function automatic logic in_high_window(input int ph, input int per);
    return (ph >= 1) && (ph <= per / 2);
  endfunction

  // Half-rate clock is high on odd positions.
  function automatic logic half_level(input int ph);
    return (ph % 2) == 1;
  endfunction

endpackage

// File: rtl/mrd_en_sync.sv
module mrd_en_sync (
  input  logic clk,
  input  logic mrst,
  input  logic en,
  output logic en_q
);
  // Captured on the falling edge: gating can only change while clk is low.
  always_ff @(negedge clk) begin
    if (mrst) en_q <= 1'b0;
    else      en_q <= en;
  end
endmodule

// File: rtl/mrd_phase_ctr.sv
module mrd_phase_ctr #(
  parameter int RATIO_LO = 4,
  parameter int RATIO_HI = 6,
  localparam int PH_W = $clog2(RATIO_HI)
) (
  input  logic clk,
  input  logic mrst,
  input  logic adv,
  input  logic ratio_sel,
  output logic half_nxt,
  output logic slow_nxt,
  output logic rise_nxt
);
  import mrd_pkg::*;

  logic [PH_W-1:0] ph_q;
  logic [PH_W-1:0] ph_nxt;
  logic            ratio_q;
  logic            ratio_use;
  logic            wrap_pt;
  int              per_val;

  // A new ratio is taken only at position 0, the edge before a shared rise.
  assign wrap_pt   = (ph_q == '0);
  assign ratio_use = wrap_pt ? ratio_sel : ratio_q;

  always_comb begin
    per_val  = ratio_use ? RATIO_HI : RATIO_LO;
    ph_nxt   = adv ? PH_W'(ph_after(int'(ph_q), per_val)) : ph_q;
    half_nxt = half_level(int'(ph_nxt));
    slow_nxt = in_high_window(int'(ph_nxt), per_val);
    rise_nxt = adv && (ph_nxt == PH_W'(1));
  end

  always_ff @(posedge clk) begin
    if (mrst) begin
      ph_q    <= '0;
      ratio_q <= 1'b0;
    end else begin
      ph_q <= ph_nxt;
      if (adv && wrap_pt) ratio_q <= ratio_sel;
    end
  end

  a_r9_ratio_only_at_wrap: assert property (@(posedge clk) disable iff (mrst)
    !wrap_pt |=> $stable(ratio_q));

  a_r1_phase_moves_when_enabled: assert property (@(posedge clk) disable iff (mrst)
    adv |=> (ph_q != $past(ph_q)));

endmodule

// File: rtl/mrd_out_stage.sv
module mrd_out_stage #(
  parameter int NCOPY = 2
) (
  input  logic             clk,
  input  logic             mrst,
  input  logic             load,
  input  logic             half_in,
  input  logic             slow_in,
  input  logic             mark_in,
  output logic [NCOPY-1:0] half_q,
  output logic [NCOPY-1:0] slow_q,
  output logic             mark_q
);
  for (genvar k = 0; k < NCOPY; k++) begin : g_copy
    always_ff @(posedge clk) begin
      if (mrst) begin
        half_q[k] <= 1'b0;
        slow_q[k] <= 1'b0;
      end else if (load) begin
        half_q[k] <= half_in;
        slow_q[k] <= slow_in;
      end
    end
  end

  // The marker register runs every cycle, so it always clears after one.
  always_ff @(posedge clk) begin
    if (mrst) mark_q <= 1'b0;
    else      mark_q <= mark_in;
  end

  a_r1_half_toggles: assert property (@(posedge clk) disable iff (mrst)
    load |=> (half_q[0] != $past(half_q[0])));

  a_r6_hold_when_gated: assert property (@(posedge clk) disable iff (mrst)
    !load |=> ($stable(half_q) && $stable(slow_q)));

  a_r7_mark_single_cycle: assert property (@(posedge clk) disable iff (mrst)
    mark_q |=> !mark_q);

endmodule

// File: rtl/mrd_clk_divider.sv
module mrd_clk_divider #(
  parameter int RATIO_LO = 4,
  parameter int RATIO_HI = 6,
  parameter int NCOPY    = 2
) (
  input  logic             clk,
  input  logic             mrst,
  input  logic             en,
  input  logic             ratio_sel,
  output logic [NCOPY-1:0] div2_o,
  output logic [NCOPY-1:0] divn_o,
  output logic             phase_o
);
  logic en_q;
  logic half_nxt;
  logic slow_nxt;
  logic rise_nxt;

  mrd_en_sync u_en (
    .clk  (clk),
    .mrst (mrst),
    .en   (en),
    .en_q (en_q)
  );

  mrd_phase_ctr #(
    .RATIO_LO (RATIO_LO),
    .RATIO_HI (RATIO_HI)
  ) u_ctr (
    .clk       (clk),
    .mrst      (mrst),
    .adv       (en_q),
    .ratio_sel (ratio_sel),
    .half_nxt  (half_nxt),
    .slow_nxt  (slow_nxt),
    .rise_nxt  (rise_nxt)
  );

  mrd_out_stage #(
    .NCOPY (NCOPY)
  ) u_out (
    .clk     (clk),
    .mrst    (mrst),
    .load    (en_q),
    .half_in (half_nxt),
    .slow_in (slow_nxt),
    .mark_in (rise_nxt),
    .half_q  (div2_o),
    .slow_q  (divn_o),
    .mark_q  (phase_o)
  );

  a_r4_shared_rise: assert property (@(posedge clk) disable iff (mrst)
    $rose(divn_o[0]) |-> $rose(div2_o[0]));

  a_r7_mark_with_rise: assert property (@(posedge clk) disable iff (mrst)
    phase_o |-> (div2_o[0] && divn_o[0] && $rose(divn_o[0])));

endmodule

// File: tb/sim_mrd_clk_divider.sv
module sim_mrd_clk_divider;
  localparam int NC = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic mrst = 1'b1;
  logic en = 1'b0;
  logic ratio_sel = 1'b0;
  logic [NC-1:0] div2_o;
  logic [NC-1:0] divn_o;
  logic phase_o;

  mrd_clk_divider #(.RATIO_LO(4), .RATIO_HI(6), .NCOPY(NC)) u0 (
    .clk(clk), .mrst(mrst), .en(en), .ratio_sel(ratio_sel),
    .div2_o(div2_o), .divn_o(divn_o), .phase_o(phase_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Behavioural reference: enable seen at falling edge, position/period integers.
  bit m_en, m_used, m_used_prev, m_d2, m_dn, m_ph, m_dn_prev, m_pend, m_rst;
  int m_pos = 0;
  int m_per = 4;

  always @(negedge clk) m_en = mrst ? 1'b0 : en;

  always @(posedge clk) begin
    m_dn_prev   = m_dn;
    m_used_prev = m_used;
    m_used      = m_en;
    m_rst       = mrst;
    if (mrst) begin
      m_pos = 0; m_per = 4; m_d2 = 0; m_dn = 0; m_ph = 0; m_used = 0;
    end else begin
      m_ph = 0;
      if (m_en) begin
        if (m_pos == 0) m_per = ratio_sel ? 6 : 4;
        m_pos = (m_pos + 1) % m_per;
        m_d2  = (m_pos % 2) == 1;
        m_dn  = (m_pos >= 1) && (m_pos <= m_per / 2);
        m_ph  = (m_pos == 1);
      end
    end
    m_pend = ((ratio_sel ? 6 : 4) != m_per) && (m_pos != 0);
  end

  always @(posedge clk) begin
    string t2, tn;
    #6;
    if (!done) begin
      if (m_rst) begin t2 = "R8"; tn = "R8"; end
      else if (m_used != m_used_prev) begin t2 = "R5"; tn = "R5"; end
      else if (!m_used) begin t2 = "R6"; tn = "R6"; end
      else begin
        t2 = "R1";
        tn = m_pend ? "R9" : ((m_per == 6) ? "R3" : "R2");
      end
      chk(t2, div2_o[0], m_d2, "half-rate output");
      chk(tn, divn_o[0], m_dn, "slow output");
      chk("R7", phase_o, m_ph, "phase marker");
      for (int k = 1; k < NC; k++) begin
        chk("R10", div2_o[k], div2_o[0], "half-rate copy");
        chk("R10", divn_o[k], divn_o[0], "slow copy");
      end
      if (m_dn && !m_dn_prev) chk("R4", div2_o[0], 1'b1, "half-rate high at shared rise");
    end
  end

  task automatic step(input bit e, input bit s, input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      en = e; ratio_sel = s;
    end
  endtask

  initial begin
    int lfsr = 32'h1d3a;
    step(0, 0, 3);
    mrst = 1'b0;
    step(0, 0, 3);            // R8: released but not enabled, outputs low
    step(1, 0, 18);           // divide by 4
    step(1, 1, 1);            // request divide by 6 mid-period (R9)
    step(1, 1, 30);
    step(1, 0, 2);            // request back to divide by 4
    step(1, 0, 20);
    step(0, 0, 5);            // gating (R6)
    step(1, 1, 7);
    for (int i = 0; i < 120; i++) begin
      lfsr = (lfsr << 1) ^ (((lfsr >> 15) ^ (lfsr >> 13)) & 1);
      step(bit'(lfsr[0] | lfsr[3]), bit'(lfsr[5]), 1);
    end
    @(posedge clk); #2; mrst = 1'b1;
    step(1, 1, 2);
    mrst = 1'b0;
    step(1, 1, 25);
    @(posedge clk); #7;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule